// File: doc/BRIEF.md
# Configuration Port Abort Sequencer

This block runs the abort handshake on a byte-wide parallel configuration port whose clock is driven by the controller, not free-running. When the host pulses a request, the block lowers chip select in write direction, then flips the read/write select to read while chip select stays low. That flip is what the target sees as an abort. The block keeps clocking and gathers the status bytes the target drives back. It then raises chip select to end the abort and reports the captured 32-bit word together with two decoded flags.

A host issues one abort just before a scrub pass that must leave block RAM contents intact, and a second one just after it. The block accepts a new request in the cycle after it finishes, so the two aborts can run back to back. The configuration clock toggles at half the system clock rate and only while a sequence is running. Chip select and read/write select change only while the configuration clock is low, so the target never sees them move on its sampling edge.

Top module: `cfg_abort_seq`

## Requirements
- R1: After reset: cs_n=1, rdwr_n=0, cclk=0, busy=0, done=0, status=0, sync_seen=0, abort_seen=0.
- R2: A req sampled while idle starts a sequence. For one cclk period chip select is low with rdwr_n=0 (write). rdwr_n then goes to 1 while cs_n stays low.
- R3: While busy, cclk is a square wave at half the clk rate: low for one clk cycle, then high for one. It stays low while idle. A full sequence gives exactly 7 rising cclk edges. cs_n and rdwr_n change only while cclk is low.
- R4: After the select flip, the block samples din on NB=4 further rising cclk edges. The first byte lands in status[31:24] and the last byte in status[7:0]. The abort therefore spans at least four cclk cycles with cs_n low and rdwr_n high.
- R5: After the last byte, cs_n goes high while rdwr_n is still 1, for one cclk period. The port then returns to idle with cs_n=1 and rdwr_n=0.
- R6: done is a one-cycle pulse. It is high 14 clk cycles after the edge that sampled req, with cs_n=1 and busy=0. status, sync_seen and abort_seen update together with done and hold until the next completion.
- R7: sync_seen is bit 6 of the last byte. abort_seen is the inverse of bit 4 of that byte. Examples: 0xDF gives 1/0, 0xCF gives 1/1, 0x8F gives 0/1, 0x9F gives 0/0.
- R8: A req arriving while busy is ignored. The running sequence keeps its timing, produces exactly one done, and the block is idle afterwards.
- R9: A req sampled in the cycle that done is high starts a new sequence at once, so two aborts can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an abort sequence |
| din | input | 8 | Status byte driven by the target |
| cclk | output | 1 | Controlled configuration clock |
| cs_n | output | 1 | Active-low chip select |
| rdwr_n | output | 1 | Read/write select, 1 = read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Captured status word |
| sync_seen | output | 1 | Target reports sync word received |
| abort_seen | output | 1 | Target reports abort taken |

## Verification
Every output is fixed to a known clk count after the edge that samples req:
- chip select falls in that same cycle;
- the select flip is visible two cycles later;
- the release is visible at cycle 13;
- done is visible at cycle 14.

The bench counts falling clk edges from the request and samples at exactly those counts. The target model drives each byte one time unit after a rising cclk edge, so the next edge samples the byte it presented. A separate counter checks that each sequence produces exactly seven rising cclk edges.

// File: rtl/cfg_abort_seq.sv
`timescale 1ns/1ps
module cfg_abort_seq #(
  parameter int DW       = 8,
  parameter int NB       = 4,
  parameter int SYNC_BIT = 6,
  parameter int ABT_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DW-1:0]    din,
  output logic             cclk,
  output logic             cs_n,
  output logic             rdwr_n,
  output logic             busy,
  output logic             done,
  output logic [DW*NB-1:0] status,
  output logic             sync_seen,
  output logic             abort_seen
);
  localparam int SW = DW * NB;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_TOG, S_CAP, S_REL} st_t;

  st_t           st;
  logic          ph;
  logic [CW-1:0] cnt;
  logic [SW-1:0] shreg;

  assign cclk   = ph;
  assign busy   = (st != S_IDLE);
  assign cs_n   = (st == S_IDLE) || (st == S_REL);
  assign rdwr_n = (st == S_TOG) || (st == S_CAP) || (st == S_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ph         <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      status     <= '0;
      done       <= 1'b0;
      sync_seen  <= 1'b0;
      abort_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) ph <= 1'b0;
      else              ph <= ~ph;
      case (st)
        S_IDLE: if (req) begin
          st  <= S_SEL;
          cnt <= '0;
        end
        S_SEL: if (ph) st <= S_TOG;
        S_TOG: if (ph) st <= S_CAP;
        S_CAP: begin
          if (!ph) shreg <= {shreg[SW-DW-1:0], din};
          else if (cnt == CW'(NB-1)) begin
            st  <= S_REL;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_REL: if (ph) begin
          st         <= S_IDLE;
          done       <= 1'b1;
          status     <= shreg;
          sync_seen  <= shreg[SYNC_BIT];
          abort_seen <= ~shreg[ABT_BIT];
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_abort_seq_chk.sv
`timescale 1ns/1ps
module cfg_abort_seq_chk #(
  parameter int NB = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        cclk,
  input logic        cs_n,
  input logic        rdwr_n,
  input logic        busy,
  input logic        done,
  input logic [31:0] status,
  input logic        sync_seen,
  input logic        abort_seen
);
  logic [7:0] rises;
  logic       cclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cclk_q <= cclk;
      if (cs_n) rises <= '0;
      else if (rdwr_n && cclk && !cclk_q && rises != 8'hFF) rises <= rises + 1'b1;
    end
  end

  p_flip_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdwr_n) |-> !cs_n);
  p_start_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
  p_ctrl_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cs_n) || !$stable(rdwr_n)) |-> !cclk);
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cclk);
  p_min_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rises >= 8'(NB)));
  p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> rdwr_n);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sync_seen == status[6] && abort_seen == !status[4]));
endmodule

bind cfg_abort_seq cfg_abort_seq_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cclk(cclk), .cs_n(cs_n),
  .rdwr_n(rdwr_n), .busy(busy), .done(done), .status(status),
  .sync_seen(sync_seen), .abort_seen(abort_seen)
);

// File: tb/tb_cfg_abort_seq.sv
`timescale 1ns/1ps
module tb_cfg_abort_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        cclk, cs_n, rdwr_n, busy, done, sync_seen, abort_seen;
  logic [31:0] status;

  int n_run = 0, n_fail = 0;
  int rises = 0;
  int idx = 0;
  logic [31:0] pat = 32'h0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_abort_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .din(din), .cclk(cclk),
    .cs_n(cs_n), .rdwr_n(rdwr_n), .busy(busy), .done(done),
    .status(status), .sync_seen(sync_seen), .abort_seen(abort_seen)
  );

  always @(posedge cclk) begin
    rises = rises + 1;
    if (!cs_n && rdwr_n) begin
      #1;
      din = (idx < 4) ? pat[31 - 8*idx -: 8] : 8'h00;
      idx = idx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1 && rdwr_n === 1'b0, "R1 port idle", {30'd0, cs_n, rdwr_n}, 32'h2);
    chk(cclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 clock/busy/done", {29'd0, cclk, busy, done}, 32'h0);
    chk(status === 32'h0 && sync_seen === 1'b0 && abort_seen === 1'b0, "R1 status", status, 32'h0);
    repeat (4) @(negedge clk);
    chk(rises == 0, "R3 no cclk while idle", rises, 0);
  endtask

  task automatic t_abort(input logic [31:0] p, input bit exp_sync, input bit exp_abt, input bit poke_busy, input string nm);
    int lat = 0;
    int dones = 0;
    pat = p; idx = 0; rises = 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, {nm, " R9/R2 accepted"}, busy, 1);
    chk(cs_n === 1'b0 && rdwr_n === 1'b0, {nm, " R2 select write"}, {cs_n, rdwr_n}, 0);
    while (done !== 1'b1 && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 2)
        chk(cs_n === 1'b0 && rdwr_n === 1'b1, {nm, " R2 flip under cs"}, {cs_n, rdwr_n}, 1);
      if (lat == 5 && poke_busy) req = 1'b1;
      if (lat == 6) req = 1'b0;
      if (lat == 13)
        chk(cs_n === 1'b1 && rdwr_n === 1'b1, {nm, " R5 release read"}, {cs_n, rdwr_n}, 3);
    end
    chk(lat == 14, {nm, " R6 latency"}, lat, 14);
    chk(cs_n === 1'b1 && rdwr_n === 1'b0 && busy === 1'b0, {nm, " R5/R6 idle at done"}, {cs_n, rdwr_n, busy}, 4);
    chk(status === p, {nm, " R4 status word"}, status, p);
    chk(sync_seen === exp_sync && abort_seen === exp_abt, {nm, " R7 flags"}, {sync_seen, abort_seen}, {exp_sync, exp_abt});
    chk(rises == 7, {nm, " R3 cclk edges"}, rises, 7);
    if (poke_busy) begin
      dones = 1;
      repeat (20) begin
        @(negedge clk);
        if (done === 1'b1) dones++;
      end
      chk(dones == 1 && busy === 1'b0, "R8 busy request ignored", dones, 1);
      chk(status === p, "R8 status held", status, p);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_abort(32'hA5C311DF, 1'b1, 1'b0, 1'b0, "sync_noabort");
    repeat (3) @(negedge clk);
    t_abort(32'h010203CF, 1'b1, 1'b1, 1'b0, "sync_abort");
    repeat (2) @(negedge clk);
    t_abort(32'hFFEEDD8F, 1'b0, 1'b1, 1'b0, "nosync_abort");
    repeat (2) @(negedge clk);
    t_abort(32'h5A5A5A9F, 1'b0, 1'b0, 1'b1, "nosync_noabort");
    t_abort(32'h123456CF, 1'b1, 1'b1, 1'b0, "pre_scrub");
    t_abort(32'h9ABCDEDF, 1'b1, 1'b0, 1'b0, "post_scrub_R9");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule